// File: doc/BRIEF.md
# Setup-Masked Address Window with Direct Translation

This block holds one configuration base address register whose size, type and enable come from a companion setup register. Loader firmware or a management agent writes the setup register once at bring-up. After that, each address bit of the base register can be written only if the matching setup bit is one. All other base bits read as zero, and writes to them are dropped. The low attribute bits of the base register are read-only copies of the setup register, so software can see the window type.

The block also decodes upstream requests against the window. A request hits when its space type matches the window and its address bits under the setup mask equal the programmed base. On a hit, the masked upper bits of the address are replaced with the same bits of a translated-base register, and the offset bits pass through unchanged. Decode and translation are combinational. Register writes take effect at the clock edge.

Top module: `bar_xlat_window`

## Requirements
- R1: After reset, the base, setup and translated-base registers all read zero, and no request hits.
- R2: For a valid memory window, base bit 0 reads 0, bits 2:1 read the type code 00 and bit 3 reads setup bit 3 (prefetchable). For a valid I/O window, base bit 0 reads 1 and bit 1 reads 0.
- R3: The writable base bits are setup bits 31:4 for memory and 31:2 for I/O. Every other address bit reads zero and ignores writes.
- R4: When setup bit 31 is zero, the window is disabled. The base register reads all zeros and no request hits.
- R5: A setup value also disables the window when any of the following holds:
  - its mask is not one run of ones from bit 31 down;
  - it is a memory window with a size below 4 KB (any of setup bits 11:4 set);
  - it is a memory window with a type code other than 00;
  - it is an I/O window outside 64 B to 256 B (any of bits 5:2 set, or bit 8 clear).
- R6: A request hits when the window is valid, the request's space matches, and (addr & mask) == (base & mask).
- R7: A memory request never hits an I/O window, and an I/O request never hits a memory window. Setup bit 0 selects I/O (1) or memory (0).
- R8: On a hit, the translated address is (xbase & mask) | (addr & ~mask).
- R9: A request presented in the same cycle as a base write is decoded against the base value held before that write.
- R10: The translated-base register reads back its full written value. Select codes: 0 base, 1 setup, 2 translated base. Select 3 reads zero and its writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 base, 1 setup, 2 translated base) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected register |
| req_valid | input | 1 | Upstream request present |
| req_io | input | 1 | Request is I/O space (1) or memory (0) |
| req_addr | input | 32 | Request address |
| hit | output | 1 | Request falls in the window |
| xlat_addr | output | 32 | Translated address |

## Verification
A base-register write and an upstream decode can happen in the same cycle. The decode path is combinational, and the write lands only at the next edge. The bench provokes this by raising the write strobe with a new base while it presents a request aimed at the old base. It checks that the request hits in that cycle. In the following cycle, the same address must miss and the new base must hit.

// File: rtl/bar_xlat_window.sv
module bar_xlat_window #(
  parameter int MEM_MIN_LOG2 = 12,
  parameter int IO_MIN_LOG2  = 6,
  parameter int IO_MAX_LOG2  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  input  logic        req_io,
  input  logic [31:0] req_addr,
  output logic        hit,
  output logic [31:0] xlat_addr
);
  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_SETUP = 2'd1;
  localparam logic [1:0] SEL_XBASE = 2'd2;

  logic [31:0] base_q, setup_q, xbase_q;

  wire         is_io    = setup_q[0];
  wire  [31:0] fld_mask = is_io ? {setup_q[31:2], 2'b00} : {setup_q[31:4], 4'b0000};
  wire  [31:0] inv_mask = ~fld_mask;
  wire         contig   = ((inv_mask & (inv_mask + 32'd1)) == 32'd0);
  wire         mem_ok   = !is_io && (fld_mask[MEM_MIN_LOG2-1:0] == '0) && (setup_q[2:1] == 2'b00);
  wire         io_ok    = is_io && (fld_mask[IO_MIN_LOG2-1:0] == '0) && fld_mask[IO_MAX_LOG2];
  wire         win_ok   = setup_q[31] && contig && (mem_ok || io_ok);
  wire  [31:0] wr_mask  = win_ok ? fld_mask : 32'd0;
  wire  [31:0] attr     = !win_ok ? 32'd0 : (is_io ? 32'd1 : {28'd0, setup_q[3], 3'b000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      setup_q <= '0;
      xbase_q <= '0;
    end else if (cfg_wr) begin
      case (cfg_sel)
        SEL_BASE:  base_q  <= cfg_wdata & wr_mask;
        SEL_SETUP: setup_q <= cfg_wdata;
        SEL_XBASE: xbase_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_sel)
      SEL_BASE:  cfg_rdata = (base_q & wr_mask) | attr;
      SEL_SETUP: cfg_rdata = setup_q;
      SEL_XBASE: cfg_rdata = xbase_q;
      default:   cfg_rdata = 32'd0;
    endcase
  end

  assign hit       = req_valid && win_ok && (req_io == is_io) &&
                     ((req_addr & wr_mask) == (base_q & wr_mask));
  assign xlat_addr = (xbase_q & wr_mask) | (req_addr & ~wr_mask);

  property p_reset_clear;
    @(posedge clk) !rst_n |=> (base_q == 32'd0 && setup_q == 32'd0 && xbase_q == 32'd0);
  endproperty
  assert_reset_clear_R1: assert property (p_reset_clear);

  assert_base_masked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == SEL_BASE) |=> (base_q == ($past(cfg_wdata) & $past(wr_mask))));

  assert_base_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel != SEL_BASE) |=> $stable(base_q));

  assert_hit_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (setup_q[31] && fld_mask[31]));

  assert_hit_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (req_io == setup_q[0]));

  assert_hit_matches_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (((req_addr ^ base_q) & fld_mask) == 32'd0));

  assert_xlat_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (((xlat_addr ^ req_addr) & ~fld_mask) == 32'd0));
endmodule

// File: tb/bar_xlat_window_tb.sv
module bar_xlat_window_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_io = 1'b0;
  logic [31:0] req_addr = 32'd0;
  logic        hit;
  logic [31:0] xlat_addr;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bar_xlat_window dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_io(req_io), .req_addr(req_addr), .hit(hit), .xlat_addr(xlat_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic probe(input logic io, input logic [31:0] a, output logic h, output logic [31:0] x);
    @(negedge clk);
    req_valid = 1'b1; req_io = io; req_addr = a;
    #1 h = hit; x = xlat_addr;
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] size_mask(input int k);
    return 32'hFFFF_FFFF << k;
  endfunction

  task automatic bad_setup(input logic [31:0] s, input logic io, input string tag);
    logic [31:0] r, x;
    logic h;
    wr(2'd1, s);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, r);
    check({tag, " base reads zero"}, r, 32'd0);
    probe(io, 32'd0, h, x);
    check({tag, " no hit"}, {31'd0, h}, 32'd0);
  endtask

  initial begin
    logic [31:0] r, x, m, base, a, xb;
    logic h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], r);
      check("R1 reset read", r, 32'd0);
    end
    probe(1'b0, 32'd0, h, x);
    check("R1 reset no hit", {31'd0, h}, 32'd0);

    for (int k = 12; k <= 31; k++) begin
      logic pf;
      pf = k[0];
      m  = size_mask(k);
      wr(2'd1, m | {28'd0, pf, 3'b000});
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, r);
      check("R2 R3 mem attr and mask", r, m | {28'd0, pf, 3'b000});
      base = 32'hA5A5_5A5A & m;
      xb   = 32'h3C3C_C3C3 ^ (32'd1 << k);
      wr(2'd0, 32'hA5A5_5A5A);
      wr(2'd2, xb);
      rd(2'd2, r);
      check("R10 xbase readback", r, xb);
      a = base | (32'h1234_5678 & ~m);
      probe(1'b0, a, h, x);
      check("R6 mem hit", {31'd0, h}, 32'd1);
      check("R8 mem xlat", x, (xb & m) | (a & ~m));
      probe(1'b1, a, h, x);
      check("R7 io req on mem window", {31'd0, h}, 32'd0);
      probe(1'b0, a ^ (32'd1 << k), h, x);
      check("R6 mem miss", {31'd0, h}, 32'd0);
    end

    for (int k = 6; k <= 8; k++) begin
      m = size_mask(k);
      wr(2'd1, m | 32'd1);
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, r);
      check("R2 R3 io attr and mask", r, m | 32'd1);
      base = 32'h0000_C3C0 & m;
      wr(2'd0, base);
      xb = 32'h7700_1100;
      wr(2'd2, xb);
      a = base | (32'h0000_00FF & ~m);
      probe(1'b1, a, h, x);
      check("R6 io hit", {31'd0, h}, 32'd1);
      check("R8 io xlat", x, (xb & m) | (a & ~m));
      probe(1'b0, a, h, x);
      check("R7 mem req on io window", {31'd0, h}, 32'd0);
    end

    bad_setup(32'h7FFF_F000, 1'b0, "R4 enable clear");
    bad_setup(32'hFF0F_0000, 1'b0, "R5 non-contiguous");
    bad_setup(32'hFFFF_FF00, 1'b0, "R5 mem too small");
    bad_setup(32'hFFFF_F002, 1'b0, "R5 mem type code");
    bad_setup(32'hFFFF_FFE1, 1'b1, "R5 io too small");
    bad_setup(32'hFFFF_FE01, 1'b1, "R5 io too big");

    wr(2'd1, 32'hFFFF_0000);
    wr(2'd0, 32'h1234_0000);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h5678_0000;
    req_valid = 1'b1; req_io = 1'b0; req_addr = 32'h1234_0010;
    #1 check("R9 same-cycle uses old base", {31'd0, hit}, 32'd1);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1 check("R9 old base misses after write", {31'd0, hit}, 32'd0);
    req_addr = 32'h5678_0010;
    #1 check("R9 new base hits", {31'd0, hit}, 32'd1);
    req_valid = 1'b0;
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, r);
    check("R10 select 3 reads zero", r, 32'd0);
    rd(2'd0, r);
    check("R10 select 3 write leaves base", r, 32'h5678_0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule